// File: doc/BRIEF.md
# Banked UART Register Front-End

This block sits on the register path between a word-addressed bus and a standard 16550-style UART core. It adds a bank of extended registers without changing the core. The block keeps local copies of the line control and modem control values by watching writes that are still passed to the core. From those copies and an enable bit in a local feature register, it decides whether an access at a shared offset goes to the core or to one of the local registers.

Locally it holds a feature register, a pair of XON characters, a pair of XOFF characters, a transmit-control register, a trigger-level register and a mode register. Any access the bank does not claim reaches the core unchanged: the same address, the same write data and the same strobe. Read data is chosen combinationally from the current address and the register state. A write that changes the bank selection takes effect on the next cycle.

Top module: `uart_bank_frontend`

## Requirements
- R1: After reset the transmit-control register holds 0x0F. The line control copy, modem control copy, feature register, trigger-level register, mode register and both XON and XOFF characters hold 0x00.
- R2: A write at byte offset 0x0C always reaches the core and always loads the line control copy with the written byte. Reads at 0x0C return the core's data.
- R3: When the line control copy equals 0xBF, reads and writes at offset 0x08 use the local feature register and raise no core strobe. With any other line control value, offset 0x08 goes to the core.
- R4: When the line control copy equals 0xBF, offsets 0x10 and 0x14 access XON character 0 and 1, and offsets 0x18 and 0x1C access XOFF character 0 and 1. The character index is address bit 2. No core strobe is raised.
- R5: When the line control copy is not 0xBF, a write at 0x10 reaches the core and loads the modem control copy with the byte ANDed with 0x7F.
- R6: When the line control copy is not 0xBF, a read at 0x10 returns the core's data ORed with bits 7:5 of the modem control copy.
- R7: When feature bit 4 and modem control copy bit 6 are both 1, offset 0x18 accesses the transmit-control register and offset 0x1C accesses the trigger-level register. This applies whatever the line control value is, and it overrides the XOFF mapping.
- R8: Offset 0x20 is the local mode register. Writes store the byte ANDed with 0x7F, reads return the stored value, and the core never sees a strobe at this offset.
- R9: Every access that is not claimed locally reaches the core in the same cycle with the same address, data and strobe, and its read data is the core's data. This covers offsets 0x00, 0x04, 0x24 and above, and the shared offsets when their bank is not selected.
- R10: A write that changes the line control copy, the modem control copy or the feature register changes the decode from the next cycle on. The write itself is decoded with the state that held before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (6) | Byte address; bits 1:0 ignored |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| core_addr | output | ADDR_W (6) | Address to core |
| core_wr_en | output | 1 | Write strobe to core |
| core_rd_en | output | 1 | Read strobe to core |
| core_wdata | output | 8 | Write data to core |
| core_rdata | input | 8 | Read data from core |

## Verification
A wrong line control or modem control copy shows up as a wrong bank decision. The very next access at a shared offset then either raises a core strobe it should not raise, or returns core data where a local value belongs, so the error appears within one access. A corrupted local register is seen on its next read-back, and corrupted masking is seen on the next read of 0x10 or 0x20. The bench sweeps every word offset under each combination of line control key, feature enable and modem enable, and compares the result against an arithmetic model.

// File: rtl/ufe_pkg.sv
package ufe_pkg;

  typedef enum logic [2:0] {
    SEL_CORE = 3'd0,
    SEL_FEAT = 3'd1,
    SEL_XON  = 3'd2,
    SEL_XOFF = 3'd3,
    SEL_TXC  = 3'd4,
    SEL_TRG  = 3'd5,
    SEL_MODE = 3'd6
  } sel_e;

  typedef struct packed {
    sel_e sel;        // target of this access
    logic idx;        // pair index (address bit 2)
    logic snoop_lcr;  // line control copy loads on write
    logic snoop_mcr;  // modem control copy loads on write
    logic merge_mcr;  // read data merges modem control bits
  } dec_t;

  // keep the low n bits of an 8-bit value
  function automatic logic [7:0] f_keep_low(input logic [7:0] v, input int unsigned n);
    logic [7:0] m;
    m = 8'((9'd1 << n) - 9'd1);
    return v & m;
  endfunction

  // pick one byte of a pair
  function automatic logic [7:0] f_pick(input logic [1:0][7:0] pair, input logic idx);
    return idx ? pair[1] : pair[0];
  endfunction

endpackage

// File: rtl/ufe_decode.sv
module ufe_decode
  import ufe_pkg::*;
#(
  parameter int          WORD_W   = 4,
  parameter logic [7:0]  LCR_KEY  = 8'hBF,
  parameter int          FEAT_BIT = 4,
  parameter int          MCR_BIT  = 6
) (
  input  logic [WORD_W-1:0] word,
  input  logic [7:0]        lcr_q,
  input  logic [7:0]        feat_q,
  input  logic [7:0]        mcr_q,
  output dec_t              dec,
  output logic              bank_key,
  output logic              txc_en
);
  localparam logic [WORD_W-1:0] W_FEAT = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_LCR  = WORD_W'(3);
  localparam logic [WORD_W-1:0] W_MCR  = WORD_W'(4);
  localparam logic [WORD_W-1:0] W_XON1 = WORD_W'(5);
  localparam logic [WORD_W-1:0] W_TXC  = WORD_W'(6);
  localparam logic [WORD_W-1:0] W_TRG  = WORD_W'(7);
  localparam logic [WORD_W-1:0] W_MODE = WORD_W'(8);

  always_comb begin
    bank_key = (lcr_q == LCR_KEY);
    txc_en   = feat_q[FEAT_BIT] & mcr_q[MCR_BIT];
    dec      = '0;
    dec.sel  = SEL_CORE;
    dec.idx  = word[0];
    unique case (word)
      W_FEAT: if (bank_key) dec.sel = SEL_FEAT;
      W_LCR:  dec.snoop_lcr = 1'b1;
      W_MCR, W_XON1: begin
        if (bank_key) begin
          dec.sel = SEL_XON;
        end else if (word == W_MCR) begin
          dec.snoop_mcr = 1'b1;
          dec.merge_mcr = 1'b1;
        end
      end
      W_TXC, W_TRG: begin
        if (txc_en)        dec.sel = word[0] ? SEL_TRG : SEL_TXC;
        else if (bank_key) dec.sel = SEL_XOFF;
      end
      W_MODE: dec.sel = SEL_MODE;
      default: dec.sel = SEL_CORE;
    endcase
  end
endmodule

// File: rtl/ufe_regs.sv
module ufe_regs
  import ufe_pkg::*;
#(
  parameter logic [7:0] TXC_RST  = 8'h0F,
  parameter int         MCR_KEEP = 7,
  parameter int         MODE_KEEP = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wdata,
  input  dec_t            dec,
  output logic [7:0]      lcr_q,
  output logic [7:0]      mcr_q,
  output logic [7:0]      feat_q,
  output logic [1:0][7:0] xon_q,
  output logic [1:0][7:0] xoff_q,
  output logic [7:0]      txc_q,
  output logic [7:0]      trg_q,
  output logic [7:0]      mode_q
);
  logic we_lcr, we_mcr, we_feat, we_xon, we_xoff, we_txc, we_trg, we_mode;

  always_comb begin
    we_lcr  = wr_en & dec.snoop_lcr;
    we_mcr  = wr_en & dec.snoop_mcr;
    we_feat = wr_en & (dec.sel == SEL_FEAT);
    we_xon  = wr_en & (dec.sel == SEL_XON);
    we_xoff = wr_en & (dec.sel == SEL_XOFF);
    we_txc  = wr_en & (dec.sel == SEL_TXC);
    we_trg  = wr_en & (dec.sel == SEL_TRG);
    we_mode = wr_en & (dec.sel == SEL_MODE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      mcr_q  <= '0;
      feat_q <= '0;
      xon_q  <= '0;
      xoff_q <= '0;
      txc_q  <= TXC_RST;
      trg_q  <= '0;
      mode_q <= '0;
    end else begin
      if (we_lcr)  lcr_q  <= wdata;
      if (we_mcr)  mcr_q  <= f_keep_low(wdata, MCR_KEEP);
      if (we_feat) feat_q <= wdata;
      if (we_xon)  xon_q[dec.idx]  <= wdata;
      if (we_xoff) xoff_q[dec.idx] <= wdata;
      if (we_txc)  txc_q  <= wdata;
      if (we_trg)  trg_q  <= wdata;
      if (we_mode) mode_q <= f_keep_low(wdata, MODE_KEEP);
    end
  end

  AST_LCR_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec.snoop_lcr) |=> (lcr_q == $past(wdata))); // R2
  AST_MCR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec.snoop_mcr) |=> (mcr_q == ($past(wdata) & 8'h7F))); // R5
  AST_MODE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec.sel == SEL_MODE) |=> (mode_q == ($past(wdata) & 8'h7F))); // R8
  AST_TXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && dec.sel == SEL_TXC) |=> $stable(txc_q)); // R7
  AST_XON_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && dec.sel == SEL_XON) |=> $stable(xon_q)); // R4
endmodule

// File: rtl/ufe_rdmux.sv
module ufe_rdmux
  import ufe_pkg::*;
#(
  parameter logic [7:0] MERGE_MASK = 8'hE0
) (
  input  dec_t            dec,
  input  logic [7:0]      core_rdata,
  input  logic [7:0]      mcr_q,
  input  logic [7:0]      feat_q,
  input  logic [1:0][7:0] xon_q,
  input  logic [1:0][7:0] xoff_q,
  input  logic [7:0]      txc_q,
  input  logic [7:0]      trg_q,
  input  logic [7:0]      mode_q,
  output logic [7:0]      rdata
);
  logic [7:0] merge_bits;

  always_comb begin
    merge_bits = dec.merge_mcr ? (mcr_q & MERGE_MASK) : 8'h00;
    unique case (dec.sel)
      SEL_FEAT: rdata = feat_q;
      SEL_XON:  rdata = f_pick(xon_q, dec.idx);
      SEL_XOFF: rdata = f_pick(xoff_q, dec.idx);
      SEL_TXC:  rdata = txc_q;
      SEL_TRG:  rdata = trg_q;
      SEL_MODE: rdata = mode_q;
      default:  rdata = core_rdata | merge_bits;
    endcase
  end
endmodule

// File: rtl/uart_bank_frontend.sv
module uart_bank_frontend
  import ufe_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter logic [7:0] LCR_KEY  = 8'hBF,
  parameter logic [7:0] TXC_RST  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] core_addr,
  output logic              core_wr_en,
  output logic              core_rd_en,
  output logic [7:0]        core_wdata,
  input  logic [7:0]        core_rdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  dec_t              dec;
  logic              bank_key, txc_en, claimed;
  logic [7:0]        lcr_q, mcr_q, feat_q, txc_q, trg_q, mode_q;
  logic [1:0][7:0]   xon_q, xoff_q;

  assign word = addr[ADDR_W-1:2];

  ufe_decode #(.WORD_W(WORD_W), .LCR_KEY(LCR_KEY), .FEAT_BIT(4), .MCR_BIT(6)) u_decode (
    .word(word), .lcr_q(lcr_q), .feat_q(feat_q), .mcr_q(mcr_q),
    .dec(dec), .bank_key(bank_key), .txc_en(txc_en)
  );

  ufe_regs #(.TXC_RST(TXC_RST), .MCR_KEEP(7), .MODE_KEEP(7)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .dec(dec),
    .lcr_q(lcr_q), .mcr_q(mcr_q), .feat_q(feat_q), .xon_q(xon_q), .xoff_q(xoff_q),
    .txc_q(txc_q), .trg_q(trg_q), .mode_q(mode_q)
  );

  ufe_rdmux #(.MERGE_MASK(8'hE0)) u_rdmux (
    .dec(dec), .core_rdata(core_rdata), .mcr_q(mcr_q), .feat_q(feat_q),
    .xon_q(xon_q), .xoff_q(xoff_q), .txc_q(txc_q), .trg_q(trg_q), .mode_q(mode_q),
    .rdata(rdata)
  );

  assign claimed    = (dec.sel != SEL_CORE);
  assign core_addr  = addr;
  assign core_wdata = wdata;
  assign core_wr_en = wr_en & ~claimed;
  assign core_rd_en = rd_en & ~claimed;

  AST_MODE_NO_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (word == WORD_W'(8)) |-> (!core_wr_en && !core_rd_en)); // R8
  AST_FEAT_NO_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_q == LCR_KEY && word == WORD_W'(2)) |-> (!core_wr_en && !core_rd_en)); // R3
  AST_LCR_ALWAYS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WORD_W'(3)) |-> core_wr_en); // R2
  AST_TXC_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_q[4] && mcr_q[6] && word == WORD_W'(6) && rd_en) |-> (rdata == txc_q && !core_rd_en)); // R7
  AST_MCR_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_q != LCR_KEY && word == WORD_W'(4)) |-> (rdata[7] == core_rdata[7])); // R6
endmodule

// File: tb/uart_bank_frontend_bench.sv
module uart_bank_frontend_bench;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata, core_wdata, core_rdata;
  logic [ADDR_W-1:0] core_addr;
  logic              core_wr_en, core_rd_en;

  int checks = 0;
  int errors = 0;

  // model state, from the requirements
  logic [7:0] m_lcr, m_mcr, m_feat, m_txc, m_trg, m_mode;
  logic [7:0] m_xon [2];
  logic [7:0] m_xoff [2];

  always #10 clk = ~clk;

  // core answers with a value derived from its address
  assign core_rdata = 8'hC0 ^ {2'b00, core_addr};

  uart_bank_frontend #(.ADDR_W(ADDR_W)) u_uart_bank_frontend (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .core_addr(core_addr), .core_wr_en(core_wr_en),
    .core_rd_en(core_rd_en), .core_wdata(core_wdata), .core_rdata(core_rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic bit key();
    return m_lcr == 8'hBF;
  endfunction
  function automatic bit txc_on();
    return m_feat[4] && m_mcr[6];
  endfunction
  function automatic bit m_claimed(input int w);
    case (w)
      2, 4, 5: return key();
      6, 7:    return txc_on() || key();
      8:       return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
  function automatic logic [7:0] m_read(input int w);
    logic [7:0] cv;
    cv = 8'hC0 ^ 8'(w * 4);
    case (w)
      2: return key() ? m_feat : cv;
      4: return key() ? m_xon[0] : (cv | (m_mcr & 8'hE0));
      5: return key() ? m_xon[1] : cv;
      6, 7: begin
        if (txc_on()) return (w == 6) ? m_txc : m_trg;
        if (key()) return m_xoff[w-6];
        return cv;
      end
      8: return m_mode;
      default: return cv;
    endcase
  endfunction
  function automatic string m_tag(input int w);
    case (w)
      2: return key() ? "R3" : "R9";
      3: return "R2";
      4: return key() ? "R4" : "R6";
      5: return key() ? "R4" : "R9";
      6, 7: return txc_on() ? "R7" : (key() ? "R4" : "R9");
      8: return "R8";
      default: return "R9";
    endcase
  endfunction
  task automatic m_write(input int w, input logic [7:0] v);
    case (w)
      2: if (key()) m_feat = v;
      3: m_lcr = v;
      4, 5: if (key()) m_xon[w-4] = v; else if (w == 4) m_mcr = v & 8'h7F;
      6, 7: begin
        if (txc_on()) begin if (w == 6) m_txc = v; else m_trg = v; end
        else if (key()) m_xoff[w-6] = v;
      end
      8: m_mode = v & 8'h7F;
      default: ;
    endcase
  endtask

  task automatic do_write(input int w, input logic [7:0] v);
    bit fwd;
    @(negedge clk);
    addr = ADDR_W'(w * 4); wdata = v; wr_en = 1'b1;
    #1;
    fwd = !m_claimed(w);
    check({m_tag(w), " core_wr_en"}, {7'd0, core_wr_en}, {7'd0, fwd});
    if (fwd) begin
      check("R9 core_wdata", core_wdata, v);
      check("R9 core_addr", {2'b00, core_addr}, 8'(w * 4));
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    m_write(w, v);
  endtask

  task automatic do_read(input int w, input string tag);
    @(negedge clk);
    addr = ADDR_W'(w * 4); rd_en = 1'b1;
    #1;
    check({tag, " rdata"}, rdata, m_read(w));
    check({tag, " core_rd_en"}, {7'd0, core_rd_en}, {7'd0, !m_claimed(w)});
    @(posedge clk);
    #1;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_lcr = 0; m_mcr = 0; m_feat = 0; m_txc = 8'h0F; m_trg = 0; m_mode = 0;
    m_xon[0] = 0; m_xon[1] = 0; m_xoff[0] = 0; m_xoff[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values visible through the normal interface
    do_read(8, "R1 mode");
    do_read(4, "R1 mcr merge");
    do_write(3, 8'hBF);
    do_read(2, "R1 feat");
    do_read(4, "R1 xon0");
    do_read(5, "R1 xon1");
    do_read(6, "R1 xoff0");
    do_read(7, "R1 xoff1");
    do_write(3, 8'h00);
    do_write(4, 8'h40);
    do_write(3, 8'hBF);
    do_write(2, 8'h10);
    do_read(6, "R1 txc reset 0F");
    do_read(7, "R1 trg reset 00");

    // R10: new bank decode appears on the cycle after the LCR write
    do_write(3, 8'h03);
    do_read(2, "R10 feat unbanked");
    do_write(3, 8'hBF);
    do_read(2, "R10 feat banked");

    // R5/R6: MCR write masks bit 7, merge on read
    do_write(3, 8'h00);
    do_write(4, 8'hFF);
    check("R5 mcr mask", m_mcr, 8'h7F);
    do_read(4, "R6 merge");

    // R8: mode register masks bit 7
    do_write(8, 8'hFF);
    do_read(8, "R8 mode masked");

    // sweep: LCR value x feature enable x modem enable x every word
    for (int li = 0; li < 4; li++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic [7:0] lv;
        lv = (li == 0) ? 8'h03 : (li == 1) ? 8'hBF : (li == 2) ? 8'hBE : 8'h00;
        do_write(3, 8'h00);
        do_write(4, cfg[1] ? 8'h65 : 8'h25);
        do_write(3, 8'hBF);
        do_write(2, cfg[0] ? 8'h13 : 8'h03);
        do_write(3, lv);
        for (int w = 0; w < 16; w++) begin
          logic [7:0] v;
          v = 8'((w * 37 + li * 11 + cfg * 5) ^ 8'h5A);
          if (w == 4) v = (v & 8'hBF) | (cfg[1] ? 8'h40 : 8'h00);
          if (w != 3) do_write(w, v);
          do_read(w, m_tag(w));
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule